// File: doc/BRIEF.md
# Four-Channel Low-Side Switch Protection Controller

This block is the digital core of a four-channel low-side switch driver. Each channel has a command bit, and a command of 1 turns that channel's switch on. An active-low enable gates all outputs together. The block turns each command into a gate-drive enable, and a protection layer sits on top of it. Each channel watches its own current-limit flag. If the flag stays up without a break for a deglitch window, that channel latches off. The channel comes back by itself after a long retry period. A thermal condition shuts down every output but holds no state. An undervoltage condition and the functional clear input both shut down every output and wipe all protection state.

Every control and status input is asynchronous to the clock and passes through a synchronizer chain before use. The gate enables and the active-low fault flag are registered. A command therefore reaches its gate output three clock edges after it changes: two synchronizer stages and one output register. The deglitch and retry windows are parameters counted in clock cycles. At 100 MHz the default values are 3.5 us and 1.2 ms.

Top module: `ls_driver_guard`

## Requirements
- R1: When no protection condition is active and the enable is low, each gate output equals its channel command bit, three clock edges after the command changes.
- R2: While the enable input is high, every gate output is 0 whatever the commands are. The outputs follow the commands again once the enable returns low.
- R3: While the clear input is high, every gate output is 0 and the fault flag is 1, even if the thermal condition is present. Command and current-limit inputs applied during the clear leave no latched fault behind.
- R4: A current-limit flag held for exactly DEGLITCH_CYC consecutive cycles latches that channel off and drives the fault flag to 0. A flag held for DEGLITCH_CYC-1 cycles latches nothing.
- R5: Any low cycle on a current-limit flag restarts that channel's deglitch count from zero. Two runs of DEGLITCH_CYC-1 cycles separated by one low cycle latch nothing.
- R6: A latched channel stays off, and the fault flag stays 0, for exactly RETRY_CYC cycles. The channel then clears by itself and follows its command again.
- R7: A latched channel forces only its own gate output to 0. The other channels keep following their commands.
- R8: While the thermal condition is present, every gate output is 0 and the fault flag is 0. Outputs resume within the normal three-edge latency after the condition drops, with no retry wait.
- R9: While the undervoltage condition is present, every gate output is 0 and the fault flag is 1. The condition clears all latched channels and all deglitch counts, so outputs follow their commands as soon as it drops.
- R10: After power-up reset every gate output is 0 and the fault flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| chan_cmd_i | input | NCH | Channel commands; 1 requests the switch on |
| en_n_i | input | 1 | Global output enable, active low |
| clear_i | input | 1 | Functional clear, active high |
| ilim_i | input | NCH | Per-channel current-limit flags |
| therm_i | input | 1 | Thermal shutdown condition |
| uv_i | input | 1 | Supply undervoltage condition |
| gate_on_o | output | NCH | Gate-drive enables; 1 turns the switch on |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The command path is driven with several distinct bit patterns: all ones, the two alternating patterns, a single bit, all zeros and the top bit alone. This separates per-channel routing errors and bit swaps from latency errors. The current-limit flag is held for one cycle less than the deglitch window, then for exactly the window, and then as two short runs split by a single low cycle. These three patterns pin down the threshold and show that the count restarts. Trips, clears, undervoltage and thermal conditions are applied on top of live commands. This shows which conditions wipe state, which only mask the outputs, and which leave the other channels alone. Measuring the exact length of the fault-low interval tests the retry counter against its parameter.

// File: rtl/lsdp_pkg.sv
package lsdp_pkg;

   // Bit positions of the control/status group inside the synchronized bus.
   localparam int CTL_EN_N  = 0;
   localparam int CTL_THERM = 1;
   localparam int CTL_UV    = 2;
   localparam int CTL_CLEAR = 3;
   localparam int CTL_BITS  = 4;

   typedef enum logic {
      OC_WATCH   = 1'b0,
      OC_TRIPPED = 1'b1
   } oc_state_e;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/lsdp_sync.sv
module lsdp_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lsdp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lsdp_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/lsdp_oc_chan.sv
module lsdp_oc_chan
   import lsdp_pkg::*;
#(
   parameter int DEGLITCH_CYC = 350,
   parameter int RETRY_CYC    = 120000
) (
   input  logic clk,
   input  logic por_n,
   input  logic wipe_i,
   input  logic ilim_i,
   output logic tripped_o
);

   localparam int DGW = cnt_width(DEGLITCH_CYC);
   localparam int RTW = cnt_width(RETRY_CYC);
   localparam logic [DGW-1:0] DG_LAST = DGW'(DEGLITCH_CYC - 1);
   localparam logic [RTW-1:0] RT_LAST = RTW'(RETRY_CYC - 1);

   oc_state_e      state;
   logic [DGW-1:0] dg_cnt;
   logic [RTW-1:0] rt_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state  <= OC_WATCH;
         dg_cnt <= '0;
         rt_cnt <= '0;
      end else if (wipe_i) begin
         state  <= OC_WATCH;
         dg_cnt <= '0;
         rt_cnt <= '0;
      end else begin
         unique case (state)
            OC_WATCH: begin
               if (!ilim_i) begin
                  dg_cnt <= '0;
               end else if (dg_cnt == DG_LAST) begin
                  state  <= OC_TRIPPED;
                  dg_cnt <= '0;
                  rt_cnt <= '0;
               end else begin
                  dg_cnt <= dg_cnt + 1'b1;
               end
            end
            OC_TRIPPED: begin
               if (rt_cnt == RT_LAST) begin
                  state  <= OC_WATCH;
                  rt_cnt <= '0;
               end else begin
                  rt_cnt <= rt_cnt + 1'b1;
               end
            end
            default: state <= OC_WATCH;
         endcase
      end
   end

   assign tripped_o = (state == OC_TRIPPED);

endmodule

// File: rtl/ls_driver_guard.sv
module ls_driver_guard
   import lsdp_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int DEGLITCH_CYC = 350,
   parameter int RETRY_CYC    = 120000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic [NCH-1:0] chan_cmd_i,
   input  logic           en_n_i,
   input  logic           clear_i,
   input  logic [NCH-1:0] ilim_i,
   input  logic           therm_i,
   input  logic           uv_i,
   output logic [NCH-1:0] gate_on_o,
   output logic           fault_n_o
);

   if (NCH < 1) begin : g_bad_nch
      $error("ls_driver_guard: NCH must be at least 1");
   end
   if (DEGLITCH_CYC < 1) begin : g_bad_dg
      $error("ls_driver_guard: DEGLITCH_CYC must be at least 1");
   end
   if (RETRY_CYC < 1) begin : g_bad_rt
      $error("ls_driver_guard: RETRY_CYC must be at least 1");
   end

   localparam int SW      = CTL_BITS + 2 * NCH;
   localparam int CMD_LO  = CTL_BITS;
   localparam int ILIM_LO = CTL_BITS + NCH;

   logic [SW-1:0]  raw_bus, syn_bus;
   logic           en_n_s, therm_s, uv_s, clear_s, wipe;
   logic [NCH-1:0] cmd_s, ilim_s, tripped;
   logic [NCH-1:0] gate_d;
   logic           fault_d;

   assign raw_bus = {ilim_i, chan_cmd_i, clear_i, uv_i, therm_i, en_n_i};

   lsdp_sync #(
      .WIDTH  (SW),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d_i   (raw_bus),
      .q_o   (syn_bus)
   );

   assign en_n_s  = syn_bus[CTL_EN_N];
   assign therm_s = syn_bus[CTL_THERM];
   assign uv_s    = syn_bus[CTL_UV];
   assign clear_s = syn_bus[CTL_CLEAR];
   assign cmd_s   = syn_bus[CMD_LO +: NCH];
   assign ilim_s  = syn_bus[ILIM_LO +: NCH];
   assign wipe    = clear_s | uv_s;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      lsdp_oc_chan #(
         .DEGLITCH_CYC (DEGLITCH_CYC),
         .RETRY_CYC    (RETRY_CYC)
      ) u_oc (
         .clk       (clk),
         .por_n     (por_n),
         .wipe_i    (wipe),
         .ilim_i    (ilim_s[c]),
         .tripped_o (tripped[c])
      );
   end

   // Priority: clear, undervoltage, thermal, per-channel trip, enable/command.
   always_comb begin
      if (clear_s)      gate_d = '0;
      else if (uv_s)    gate_d = '0;
      else if (therm_s) gate_d = '0;
      else if (en_n_s)  gate_d = '0;
      else              gate_d = cmd_s & ~tripped;
   end

   assign fault_d = ~(((|tripped) | therm_s) & ~wipe);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         gate_on_o <= '0;
         fault_n_o <= 1'b1;
      end else begin
         gate_on_o <= gate_d;
         fault_n_o <= fault_d;
      end
   end

endmodule

// File: rtl/ls_driver_guard_chk.sv
module ls_driver_guard_chk #(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           por_n,
   input logic           en_n_s,
   input logic           therm_s,
   input logic           uv_s,
   input logic           clear_s,
   input logic [NCH-1:0] tripped,
   input logic [NCH-1:0] gate_on_o,
   input logic           fault_n_o
);

   a_r2_enable_blocks: assert property (@(posedge clk) disable iff (!por_n)
      en_n_s |=> (gate_on_o == '0));

   a_r3_clear_wipes: assert property (@(posedge clk) disable iff (!por_n)
      clear_s |=> (gate_on_o == '0) && fault_n_o && (tripped == '0));

   a_r7_trip_local: assert property (@(posedge clk) disable iff (!por_n)
      (|tripped) |=> ((gate_on_o & $past(tripped)) == '0));

   a_r4_trip_flags: assert property (@(posedge clk) disable iff (!por_n)
      ((|tripped) && !clear_s && !uv_s) |=> !fault_n_o);

   a_r8_thermal_off: assert property (@(posedge clk) disable iff (!por_n)
      (therm_s && !clear_s && !uv_s) |=> (gate_on_o == '0) && !fault_n_o);

   a_r9_uv_wipes: assert property (@(posedge clk) disable iff (!por_n)
      uv_s |=> (gate_on_o == '0) && fault_n_o && (tripped == '0));

endmodule

bind ls_driver_guard ls_driver_guard_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .en_n_s    (en_n_s),
   .therm_s   (therm_s),
   .uv_s      (uv_s),
   .clear_s   (clear_s),
   .tripped   (tripped),
   .gate_on_o (gate_on_o),
   .fault_n_o (fault_n_o)
);

// File: tb/test_ls_driver_guard.sv
module test_ls_driver_guard;

   localparam int NCH = 4;
   localparam int DG  = 8;
   localparam int RT  = 50;

   logic           clk = 1'b0;
   logic           por_n = 1'b0;
   logic [NCH-1:0] cmd = '0;
   logic           en_n = 1'b0;
   logic           clr = 1'b0;
   logic [NCH-1:0] ilim = '0;
   logic           therm = 1'b0;
   logic           uv = 1'b0;
   logic [NCH-1:0] gate;
   logic           fault_n;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ls_driver_guard #(
      .NCH          (NCH),
      .DEGLITCH_CYC (DG),
      .RETRY_CYC    (RT),
      .SYNC_STAGES  (2)
   ) i_ls_driver_guard (
      .clk        (clk),
      .por_n      (por_n),
      .chan_cmd_i (cmd),
      .en_n_i     (en_n),
      .clear_i    (clr),
      .ilim_i     (ilim),
      .therm_i    (therm),
      .uv_i       (uv),
      .gate_on_o  (gate),
      .fault_n_o  (fault_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_ilim(input int ch, input int cycles);
      ilim[ch] = 1'b1;
      repeat (cycles) @(negedge clk);
      ilim[ch] = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 gates after reset", 32'(gate), 32'h0);
      chk("R10 fault after reset", 32'(fault_n), 32'h1);
      por_n = 1'b1;
      settle();
   endtask

   task automatic t_follow();
      logic [NCH-1:0] pats [6] = '{4'hF, 4'hA, 4'h5, 4'h1, 4'h0, 4'h8};
      logic [NCH-1:0] prev = '0;
      for (int i = 0; i < 6; i++) begin
         cmd = pats[i];
         repeat (2) @(negedge clk);
         chk("R1 latency hold", 32'(gate), 32'(prev));
         @(negedge clk);
         chk("R1 follow pattern", 32'(gate), 32'(pats[i]));
         prev = pats[i];
      end
   endtask

   task automatic t_enable();
      cmd = 4'hF; en_n = 1'b1; settle();
      chk("R2 enable high blocks", 32'(gate), 32'h0);
      cmd = 4'h5; settle();
      chk("R2 command change ignored", 32'(gate), 32'h0);
      en_n = 1'b0; settle();
      chk("R2 enable low resumes", 32'(gate), 32'h5);
   endtask

   task automatic t_glitch();
      cmd = 4'hF; settle();
      pulse_ilim(2, DG - 1);
      settle(); settle();
      chk("R4 short flag no trip", 32'(fault_n), 32'h1);
      pulse_ilim(2, DG - 1);
      @(negedge clk);
      pulse_ilim(2, DG - 1);
      settle(); settle();
      chk("R5 split runs no trip", 32'(fault_n), 32'h1);
      chk("R5 gates intact", 32'(gate), 32'hF);
   endtask

   task automatic t_trip_retry();
      int b = 0;
      int cnt = 0;
      cmd = 4'hF; settle();
      pulse_ilim(0, DG);
      while (fault_n && b < 10) begin @(negedge clk); b++; end
      chk("R4 full window trips", 32'(fault_n), 32'h0);
      chk("R4 tripped channel off", 32'(gate[0]), 32'h0);
      chk("R7 other channels on", 32'(gate[3:1]), 32'h7);
      while (!fault_n && cnt < 4 * RT) begin cnt++; @(negedge clk); end
      chk("R6 retry length", 32'(cnt), 32'(RT));
      chk("R6 channel back after retry", 32'(gate), 32'hF);
   endtask

   task automatic t_thermal();
      cmd = 4'hF; settle();
      therm = 1'b1; settle();
      chk("R8 thermal gates off", 32'(gate), 32'h0);
      chk("R8 thermal fault", 32'(fault_n), 32'h0);
      therm = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 resume without retry", 32'(gate), 32'hF);
      chk("R8 fault released", 32'(fault_n), 32'h1);
   endtask

   task automatic t_uv();
      cmd = 4'hF; settle();
      pulse_ilim(1, DG);
      repeat (6) @(negedge clk);
      chk("R4 trip before undervoltage", 32'(fault_n), 32'h0);
      uv = 1'b1; settle();
      chk("R9 undervoltage gates off", 32'(gate), 32'h0);
      chk("R9 undervoltage fault high", 32'(fault_n), 32'h1);
      uv = 1'b0; settle();
      chk("R9 trip cleared", 32'(gate), 32'hF);
      ilim[3] = 1'b1;
      repeat (DG - 2) @(negedge clk);
      uv = 1'b1;
      repeat (2) @(negedge clk);
      uv = 1'b0;
      repeat (3) @(negedge clk);
      ilim[3] = 1'b0;
      settle(); settle();
      chk("R9 deglitch count cleared", 32'(fault_n), 32'h1);
      chk("R9 channel still on", 32'(gate), 32'hF);
   endtask

   task automatic t_clear();
      cmd = 4'hF; settle();
      pulse_ilim(2, DG);
      repeat (6) @(negedge clk);
      chk("R4 trip before clear", 32'(fault_n), 32'h0);
      clr = 1'b1; therm = 1'b1; cmd = 4'h3; settle();
      chk("R3 clear gates off", 32'(gate), 32'h0);
      chk("R3 clear beats thermal", 32'(fault_n), 32'h1);
      therm = 1'b0;
      pulse_ilim(1, DG + 2);
      settle();
      clr = 1'b0; settle();
      chk("R3 follows command after clear", 32'(gate), 32'h3);
      chk("R3 flag during clear ignored", 32'(fault_n), 32'h1);
   endtask

   initial begin
      t_reset();
      t_follow();
      t_enable();
      t_glitch();
      t_trip_retry();
      t_thermal();
      t_uv();
      t_clear();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule